// File: doc/BRIEF.md
# Dual-Channel Interrupt Status Aggregator

This block gathers the interrupt sources of a two-channel serial controller into one 8-bit status byte. It combines that byte with an 8-bit mask to drive a single registered interrupt request. Each channel has three event flags: transmitter ready, receiver ready or FIFO full, and break change. The first channel's group also carries a counter-ready flag. The second channel's group carries an input-pin change summary. Logic outside the block produces the source events as one-cycle set and clear strobes.

The block also holds a pin-change byte. Its lower half follows the levels of four input pins. Its upper half latches a sticky flag for each pin whose change was reported. A bus read of that byte returns all eight bits and then clears only the sticky half. A host reaches the status byte, the mask and the pin-change byte through a simple read/write strobe interface with a 4-bit address.

Top module: `irq_status_agg`

## Requirements
- R1: Status bit positions: transmitter ready is bit 0 for channel 0 and bit 4 for channel 1. Receiver ready is bit 1 / bit 5. Break change is bit 2 / bit 6 (channel bit = base + 4 × channel). Counter ready is bit 3. Bit 7 is the OR of pin-change bits 7:4.
- R2: A read at address 5 returns the status byte on `rd_data` in the same cycle as `bus_rd`. The read leaves the status unchanged.
- R3: When a set strobe and a clear strobe hit the same status flag in one cycle, the flag is 1 after the clock edge.
- R4: A break-change clear for channel n clears bit 2+4n only. Every other status bit keeps its value.
- R5: A write at address 5 loads `wr_data` into the mask. The status byte is not altered.
- R6: Without a mask write, `irq` after a clock edge equals the OR of (status AND mask) as held before that edge. A status change therefore reaches `irq` one edge after the status register takes it.
- R7: The edge that takes a mask write forces `irq` low. The next edge re-evaluates it against the new mask.
- R8: A read at address 4 returns the pin-change byte: bits 3:0 are the pin levels registered at the last edge, bits 7:4 are the sticky change flags. The read then clears bits 7:4 and keeps bits 3:0. A change reported in the same cycle as the read survives the clear.
- R9: Reset clears the status, the mask, the sticky change flags and `irq`.
- R10: Reads at any address other than 4 or 5, and any cycle without `bus_rd`, return 0. Writes at any address other than 5 leave the mask and `irq` unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational from the address |
| tx_rdy_set | input | 2 | Per-channel transmitter-ready set |
| tx_rdy_clr | input | 2 | Per-channel transmitter-ready clear |
| rx_rdy_set | input | 2 | Per-channel receiver-ready set |
| rx_rdy_clr | input | 2 | Per-channel receiver-ready clear |
| brk_chg_set | input | 2 | Per-channel break-change set |
| brk_chg_clr | input | 2 | Per-channel break-change reset command |
| ctr_rdy_set | input | 1 | Counter-ready set |
| ctr_rdy_clr | input | 1 | Counter-ready clear |
| pin_delta | input | 4 | Per-pin change report |
| pin_level | input | 4 | Current pin levels |
| irq | output | 1 | Registered interrupt request |

## Verification
Read data is combinational, so it is due in the same cycle as the read strobe. The status and pin-change registers take a strobe at the next edge. `irq` follows one edge after that, and it is due exactly one edge after a mask write, when it must be low. The driver task computes each expected value from the requirements. It files each value with the cycle number at which it is due, and the monitor compares it in that cycle, a quarter period after the falling edge. An entry that is still waiting after its cycle has passed counts as a failure.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int unsigned GRP_STRIDE = 4;
   localparam int unsigned EVT_PER_CH = 3;
   localparam int unsigned OFS_TX     = 0;
   localparam int unsigned OFS_RX     = 1;
   localparam int unsigned OFS_BRK    = 2;
   localparam int unsigned OFS_AUX    = 3;
endpackage

// File: rtl/irq_agg_chan.sv
module irq_agg_chan
   import irq_agg_pkg::*;
#(
   parameter int unsigned N_EVT = EVT_PER_CH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] evt_set,
   input  logic [N_EVT-1:0] evt_clr,
   output logic [N_EVT-1:0] evt_q
);
   for (genvar b = 0; b < N_EVT; b++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          evt_q[b] <= 1'b0;
         else if (evt_set[b]) evt_q[b] <= 1'b1;
         else if (evt_clr[b]) evt_q[b] <= 1'b0;
      end

      p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
         evt_set[b] |=> evt_q[b]);
      p_clr_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (evt_clr[b] && !evt_set[b]) |=> !evt_q[b]);
   end
endmodule

// File: rtl/irq_agg_pchg.sv
module irq_agg_pchg #(
   parameter int unsigned PIN_W = 4,
   localparam int unsigned REG_W = 2 * PIN_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_clr,
   input  logic [PIN_W-1:0] delta,
   input  logic [PIN_W-1:0] level,
   output logic [REG_W-1:0] chg_q
);
   logic [PIN_W-1:0] sticky_q;
   logic [PIN_W-1:0] level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky_q <= '0;
         level_q  <= '0;
      end else begin
         sticky_q <= delta | (rd_clr ? '0 : sticky_q);
         level_q  <= level;
      end
   end

   assign chg_q = {sticky_q, level_q};

   p_rd_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && delta == '0) |=> chg_q[REG_W-1:PIN_W] == '0);
   p_keep_delta_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (delta != '0) |=> ((chg_q[REG_W-1:PIN_W] & $past(delta)) == $past(delta)));
endmodule

// File: rtl/irq_agg_req.sv
module irq_agg_req #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] stat,
   input  logic              mask_wr,
   input  logic [DATA_W-1:0] mask_wdata,
   output logic [DATA_W-1:0] mask_q,
   output logic              irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         irq    <= 1'b0;
      end else begin
         if (mask_wr) mask_q <= mask_wdata;
         irq <= mask_wr ? 1'b0 : |(stat & mask_q);
      end
   end

   p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr |=> mask_q == $past(mask_wdata));
   p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr |=> !irq);
   p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |=> !irq);
   p_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mask_wr && (stat & mask_q) != '0) |=> irq);
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
   import irq_agg_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned NUM_CH    = 2,
   parameter int unsigned PIN_W     = 4,
   parameter int unsigned STAT_ADDR = 5,
   parameter int unsigned CHG_ADDR  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic [NUM_CH-1:0] tx_rdy_set,
   input  logic [NUM_CH-1:0] tx_rdy_clr,
   input  logic [NUM_CH-1:0] rx_rdy_set,
   input  logic [NUM_CH-1:0] rx_rdy_clr,
   input  logic [NUM_CH-1:0] brk_chg_set,
   input  logic [NUM_CH-1:0] brk_chg_clr,
   input  logic              ctr_rdy_set,
   input  logic              ctr_rdy_clr,
   input  logic [PIN_W-1:0]  pin_delta,
   input  logic [PIN_W-1:0]  pin_level,
   output logic              irq
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
   localparam logic [ADDR_W-1:0] A_CHG  = ADDR_W'(CHG_ADDR);
   localparam int unsigned       CHG_W  = 2 * PIN_W;

   if (DATA_W != NUM_CH * GRP_STRIDE) begin : g_bad_width
      $error("status width must equal channel count times group stride");
   end
   if (CHG_W != DATA_W) begin : g_bad_pins
      $error("pin-change byte must match the data width");
   end
   if (NUM_CH != 2) begin : g_bad_ch
      $error("the auxiliary bits need exactly two channel groups");
   end

   logic [DATA_W-1:0] stat_w;
   logic [DATA_W-1:0] mask_q;
   logic [CHG_W-1:0]  chg_q;
   logic              ctr_q;
   logic              sel_stat, sel_chg;

   assign sel_stat = (bus_addr == A_STAT);
   assign sel_chg  = (bus_addr == A_CHG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           ctr_q <= 1'b0;
      else if (ctr_rdy_set) ctr_q <= 1'b1;
      else if (ctr_rdy_clr) ctr_q <= 1'b0;
   end

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      localparam int unsigned BASE = ch * GRP_STRIDE;
      logic [EVT_PER_CH-1:0] set_v, clr_v, q_v;

      assign set_v[OFS_TX]  = tx_rdy_set[ch];
      assign set_v[OFS_RX]  = rx_rdy_set[ch];
      assign set_v[OFS_BRK] = brk_chg_set[ch];
      assign clr_v[OFS_TX]  = tx_rdy_clr[ch];
      assign clr_v[OFS_RX]  = rx_rdy_clr[ch];
      assign clr_v[OFS_BRK] = brk_chg_clr[ch];

      irq_agg_chan #(.N_EVT(EVT_PER_CH)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .evt_set (set_v),
         .evt_clr (clr_v),
         .evt_q   (q_v)
      );

      assign stat_w[BASE +: EVT_PER_CH] = q_v;

      if (ch == 0) begin : g_aux_ctr
         assign stat_w[BASE + OFS_AUX] = ctr_q;
      end else begin : g_aux_pin
         assign stat_w[BASE + OFS_AUX] = |chg_q[CHG_W-1:PIN_W];
      end
   end

   irq_agg_pchg #(.PIN_W(PIN_W)) u_pchg (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_clr (bus_rd && sel_chg),
      .delta  (pin_delta),
      .level  (pin_level),
      .chg_q  (chg_q)
   );

   irq_agg_req #(.DATA_W(DATA_W)) u_req (
      .clk        (clk),
      .rst_n      (rst_n),
      .stat       (stat_w),
      .mask_wr    (bus_wr && sel_stat),
      .mask_wdata (wr_data),
      .mask_q     (mask_q),
      .irq        (irq)
   );

   always_comb begin
      rd_data = '0;
      if (bus_rd) begin
         if (sel_stat)     rd_data = stat_w;
         else if (sel_chg) rd_data = chg_q;
      end
   end

   p_other_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !sel_stat) |=> $stable(mask_q));
   p_rd_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && sel_stat && !ctr_rdy_set && !ctr_rdy_clr) |=> $stable(ctr_q));
   p_brk_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_chg_clr[0] && !brk_chg_set[0] && !tx_rdy_set[0] && !tx_rdy_clr[0]
       && !rx_rdy_set[0] && !rx_rdy_clr[0])
      |=> !stat_w[OFS_BRK] && $stable(stat_w[OFS_RX:OFS_TX]));
endmodule

// File: tb/tb_irq_status_agg.sv
module tb_irq_status_agg;
   localparam int CLK_P = 10;

   typedef struct {
      int         due;
      logic [7:0] val;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_rd = 1'b0, bus_wr = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic [1:0] tx_set = '0, tx_clr = '0, rx_set = '0, rx_clr = '0;
   logic [1:0] brk_set = '0, brk_clr = '0;
   logic       ctr_set = 1'b0, ctr_clr = 1'b0;
   logic [3:0] pin_delta = '0, pin_level = '0;
   logic       irq;

   int   cyc = 0;
   int   checks = 0;
   int   errors = 0;
   exp_t q_rd[$];
   exp_t q_irq[$];

   logic [6:0] m_bits;
   logic [7:0] m_mask;
   logic [7:0] m_chg;

   irq_status_agg dut (
      .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .wr_data(wr_data), .rd_data(rd_data),
      .tx_rdy_set(tx_set), .tx_rdy_clr(tx_clr),
      .rx_rdy_set(rx_set), .rx_rdy_clr(rx_clr),
      .brk_chg_set(brk_set), .brk_chg_clr(brk_clr),
      .ctr_rdy_set(ctr_set), .ctr_rdy_clr(ctr_clr),
      .pin_delta(pin_delta), .pin_level(pin_level), .irq(irq)
   );

   always #(CLK_P/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [7:0] m_stat();
      return {|m_chg[7:4], m_bits};
   endfunction

   function automatic logic upd(logic cur, logic s, logic c);
      return s ? 1'b1 : (c ? 1'b0 : cur);
   endfunction

   // monitor: compares every expectation in the cycle it is due
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_P/4);
         while (q_rd.size() > 0 && q_rd[0].due <= cyc) begin
            checks++;
            if (q_rd[0].due < cyc || rd_data !== q_rd[0].val) begin
               errors++;
               $display("FAIL %s rd_data actual %02h expected %02h (due %0d now %0d)",
                        q_rd[0].tag, rd_data, q_rd[0].val, q_rd[0].due, cyc);
            end
            void'(q_rd.pop_front());
         end
         while (q_irq.size() > 0 && q_irq[0].due <= cyc) begin
            checks++;
            if (q_irq[0].due < cyc || irq !== q_irq[0].val[0]) begin
               errors++;
               $display("FAIL %s irq actual %0b expected %0b (due %0d now %0d)",
                        q_irq[0].tag, irq, q_irq[0].val[0], q_irq[0].due, cyc);
            end
            void'(q_irq.pop_front());
         end
      end
   end

   // driver: inputs are already driven; file expectations, advance one cycle
   task automatic go(string tag);
      logic wm, e, rdc;
      logic [7:0] rv;
      wm  = bus_wr && bus_addr == 4'd5;
      rdc = bus_rd && bus_addr == 4'd4;
      e   = wm ? 1'b0 : |(m_stat() & m_mask);
      q_irq.push_back('{cyc + 1, {7'b0, e}, wm ? "R7" : "R6"});
      if (bus_rd) begin
         rv = (bus_addr == 4'd5) ? m_stat() : (bus_addr == 4'd4) ? m_chg : 8'h00;
         q_rd.push_back('{cyc, rv, tag});
      end
      for (int ch = 0; ch < 2; ch++) begin
         m_bits[4*ch]     = upd(m_bits[4*ch],     tx_set[ch],  tx_clr[ch]);
         m_bits[4*ch + 1] = upd(m_bits[4*ch + 1], rx_set[ch],  rx_clr[ch]);
         m_bits[4*ch + 2] = upd(m_bits[4*ch + 2], brk_set[ch], brk_clr[ch]);
      end
      m_bits[3] = upd(m_bits[3], ctr_set, ctr_clr);
      m_chg[7:4] = pin_delta | (rdc ? 4'h0 : m_chg[7:4]);
      m_chg[3:0] = pin_level;
      if (wm) m_mask = wr_data;
      @(negedge clk);
      bus_rd = 0; bus_wr = 0; bus_addr = '0; wr_data = '0;
      tx_set = '0; tx_clr = '0; rx_set = '0; rx_clr = '0;
      brk_set = '0; brk_clr = '0; ctr_set = 0; ctr_clr = 0; pin_delta = '0;
   endtask

   task automatic rd(logic [3:0] a, string tag);
      bus_rd = 1; bus_addr = a;
      go(tag);
   endtask

   task automatic wr(logic [3:0] a, logic [7:0] d, string tag);
      bus_wr = 1; bus_addr = a; wr_data = d;
      go(tag);
   endtask

   task automatic do_reset();
      #(CLK_P/2);
      rst_n = 0;
      m_bits = '0; m_mask = '0; m_chg = {4'h0, pin_level};
      repeat (2) @(negedge clk);
      rst_n = 1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      m_bits = '0; m_mask = '0; m_chg = '0;
      @(negedge clk);
      do_reset();
      // R9: reset state
      rd(4'd5, "R9");
      rd(4'd4, "R9");
      // R1 / R2: layout of the channel groups
      tx_set = 2'b01; go("R1");
      rd(4'd5, "R1");
      rx_set = 2'b10; go("R1");
      rd(4'd5, "R1");
      brk_set = 2'b11; ctr_set = 1; go("R1");
      rd(4'd5, "R2");
      rd(4'd5, "R2");
      // R4: break reset on channel 1 only, then channel 0
      brk_clr = 2'b10; go("R4");
      rd(4'd5, "R4");
      brk_clr = 2'b01; go("R4");
      rd(4'd5, "R4");
      // R3: set and clear on the same flag
      tx_clr = 2'b01; go("R3");
      rd(4'd5, "R3");
      tx_set = 2'b01; tx_clr = 2'b01; rx_set = 2'b01; rx_clr = 2'b01; go("R3");
      rd(4'd5, "R3");
      // R5 / R6 / R7: mask behaviour
      wr(4'd5, 8'h04, "R5");
      go("R6"); go("R6");
      rd(4'd5, "R5");
      wr(4'd5, 8'h02, "R7");
      go("R6"); go("R6");
      wr(4'd5, 8'h02, "R7");
      go("R6");
      rx_clr = 2'b01; go("R6");
      go("R6"); go("R6");
      wr(4'd5, 8'h44, "R5");
      go("R6");
      brk_set = 2'b10; go("R6");
      go("R6"); go("R6");
      // R8: pin-change byte
      pin_level = 4'hA; pin_delta = 4'h3; go("R8");
      rd(4'd5, "R1");
      rd(4'd4, "R8");
      rd(4'd4, "R8");
      pin_delta = 4'h8; go("R8");
      bus_rd = 1; bus_addr = 4'd4; pin_delta = 4'h1; go("R8");
      rd(4'd4, "R8");
      rd(4'd4, "R8");
      wr(4'd5, 8'h80, "R7");
      pin_delta = 4'h4; go("R6");
      go("R6"); go("R6");
      rd(4'd4, "R8");
      go("R6"); go("R6");
      // R10: unmapped accesses
      wr(4'd7, 8'hFF, "R10");
      go("R10"); go("R10");
      rd(4'd7, "R10");
      rd(4'd0, "R10");
      wr(4'd4, 8'hFF, "R10");
      rd(4'd5, "R10");
      // R9: reset in the middle of activity
      wr(4'd5, 8'hFF, "R7");
      tx_set = 2'b11; go("R9");
      go("R9"); go("R9");
      do_reset();
      rd(4'd5, "R9");
      pin_level = 4'h0; go("R9");
      rd(4'd4, "R9");
      go("R9"); go("R9");
      repeat (3) go("R6");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule